// File: doc/BRIEF.md
# External Cache Transaction Sequencer

This block sits between the core-side memory pipeline and a second-level cache built from synchronous SRAMs. The core hands it one command at a time on a valid/ready interface. Each command is a data read, tag read, data write or tag write, with an address and, for writes, a 64-byte line or a tag. The block issues the command on the cache port in step with a slower cache clock, streams write beats out and gathers read beats into a full line. It returns the line together with the tag captured in the first cache cycle of the read.

The cache clock is not a separate clock net here. It is described by a free-running counter in half-core-cycle slots, and from that counter the block derives, for every core cycle, whether a cache rising edge or falling edge falls inside it. Configuration inputs set the cache clock period, whether starts must sit on edges aligned with the core clock, which cache-clock edges carry data beats (rising, falling or both for double rate), and how many cache cycles of idle gap separate a write from a following read or the reverse.

Top module: `ext_cache_seq`

## Requirements
- R1: A counter `h` of half-core-cycle slots is 0 in the first core cycle after reset and advances by 2 modulo `cfg_half` each core cycle (`cfg_half` >= 4). Core cycle n holds a cache rising edge when `h` is 0 or `cfg_half`-1, and a cache falling edge when `h` equals F or F-1, where F = floor(`cfg_half`/2).
- R2: A command is accepted only in a core cycle holding a cache rising edge. When `cfg_align` is 1, it is accepted only where `h` is 0, the edge that lines up with a core-clock edge.
- R3: `cmd_ready` is 0 during reset and while a transaction is in progress. A command is taken at the clock edge ending a cycle with both `cmd_valid` and `cmd_ready` high. In the next cycle `c_start` pulses for one cycle, with `c_addr` and `c_op` holding the address and the operation. The operation codes are 00 data read, 01 tag read, 10 data write and 11 tag write, so bit 1 marks a write.
- R4: A transaction ends in its end cycle. A later command whose write bit differs from that of the last finished transaction is accepted only after at least `cfg_bubbles` cache rising edges have passed since the end cycle, counting strictly after it. A command in the same direction, or a gap of 0, adds no delay.
- R5: A beat event is a core cycle holding a rising edge with `cfg_rise_en` set, or a falling edge with `cfg_fall_en` set. A data transfer moves exactly four 128-bit beats, one on each of the first four beat events after acceptance, and its end cycle is the fourth of those events.
- R6: During a data write, on beat event j (j = 1..4), `c_wdata` holds bits [128*(j-1) +: 128] of the written line. `c_data_oe` is 1 from the cycle after acceptance through the end cycle and is 0 whenever no transfer is in progress.
- R7: During a data read, the `c_rdata` value of beat event j is placed in bits [128*(j-1) +: 128] of `rd_line`. `rd_done` pulses for one cycle, in the cycle after the end cycle, and only after a read.
- R8: Every read samples `c_tag_in` on the first cache rising edge after acceptance and returns it on `rd_tag` with `rd_done`. A tag read ends on that edge.
- R9: A tag write drives `cmd_wtag` on `c_tag_out` with `c_tag_oe` high from the cycle after acceptance until the first cache rising edge after acceptance, which ends the transfer. `c_tag_out` changes only in a cycle that follows a cache rising edge.
- R10: A read that has started is never cut short. A command held valid during the read is not accepted, and the read still returns its full line and tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_half | input | HALF_W | Cache clock period in half core cycles (>= 4) |
| cfg_align | input | 1 | Restrict starts to core-aligned cache rising edges |
| cfg_rise_en | input | 1 | Data beats on cache rising edges |
| cfg_fall_en | input | 1 | Data beats on cache falling edges |
| cfg_bubbles | input | BUB_W | Idle cache cycles on read/write turnaround |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | Operation code |
| cmd_addr | input | ADDR_W | Line address |
| cmd_wline | input | BEAT_W*BEATS | Line to write |
| cmd_wtag | input | TAG_W | Tag to write |
| rd_done | output | 1 | Read result valid pulse |
| rd_line | output | BEAT_W*BEATS | Assembled read line |
| rd_tag | output | TAG_W | Tag sampled by the read |
| c_start | output | 1 | Transaction start pulse to the cache |
| c_op | output | 2 | Operation of the current transaction |
| c_addr | output | ADDR_W | Address of the current transaction |
| c_data_oe | output | 1 | Data bus driven by the block |
| c_wdata | output | BEAT_W | Write beat |
| c_rdata | input | BEAT_W | Read beat from the cache |
| c_tag_oe | output | 1 | Tag bus driven by the block |
| c_tag_out | output | TAG_W | Tag being written |
| c_tag_in | input | TAG_W | Tag read from the cache |

## Verification
`cmd_ready` is combinational, so its value in a cycle is compared with a prediction made from that cycle's slot position, busy state and turnaround count. The `c_start`, `c_addr` and `c_op` values are due one cycle after acceptance. Write beats and the tag-write value are compared in the beat-event cycle the cache would latch them. Read beats and tags are predicted from the bench's cycle-indexed `c_rdata` and `c_tag_in` values at the beat events and the first rising edge, and `rd_done` is expected exactly one cycle after the fourth beat event. The bench samples every output at the falling core-clock edge, with the cycle index counted the same way as the slot counter, and sweeps every period from 4 to 7 half cycles, both alignment settings, all three edge selections and two gap lengths.

// File: rtl/ecs_pkg.sv
// Shared types for the external cache transaction sequencer.
// Bit 1 of an operation code marks a write and bit 0 marks a tag-only access;
// neighbouring logic decodes those two bits directly.
package ecs_pkg;

    typedef enum logic [1:0] {
        OP_DRD = 2'b00,
        OP_TRD = 2'b01,
        OP_DWR = 2'b10,
        OP_TWR = 2'b11
    } ecs_op_e;

    // True for the two write operations.
    function automatic logic op_writes(ecs_op_e op);
        return op[1];
    endfunction

    // True for the two single-transfer tag operations.
    function automatic logic op_tag_only(ecs_op_e op);
        return op[0];
    endfunction

endpackage

// File: rtl/ecs_clock_gen.sv
// Cache clock edge model.
// Tracks the cache clock phase in half-core-cycle slots and reports, for each
// core cycle, whether a cache rising or falling edge falls inside it.
// Assumes cfg_half >= 4 and that cfg_half only changes while reset is held.
module ecs_clock_gen #(
    parameter int HALF_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] cfg_half,
    output logic              rise,
    output logic              rise_al,
    output logic              fall
);

    logic [HALF_W-1:0] hcnt;
    logic [HALF_W:0]   hsum;
    logic [HALF_W-1:0] hnext;
    logic [HALF_W-1:0] fall_pos;

    // Next slot position: two half slots per core cycle, wrapped at the period.
    always_comb begin
        hsum  = {1'b0, hcnt} + (HALF_W + 1)'(2);
        hnext = (hsum >= {1'b0, cfg_half}) ? HALF_W'(hsum - {1'b0, cfg_half})
                                           : HALF_W'(hsum);
    end

    // Slot counter, zero in the first cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) hcnt <= '0;
        else        hcnt <= hnext;
    end

    // Edge decode from the slot position at the start of this core cycle.
    always_comb begin
        fall_pos = cfg_half >> 1;
        rise_al  = (hcnt == '0);
        rise     = rise_al || (hcnt == cfg_half - HALF_W'(1));
        fall     = (hcnt == fall_pos) || (hcnt == fall_pos - HALF_W'(1));
    end

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) hcnt < cfg_half) else $error("slot out of range"); // R1
    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rise && fall)) else $error("rise and fall in one cycle"); // R1

endmodule

// File: rtl/ecs_turnaround.sv
// Read/write turnaround gap.
// Loads the configured gap at the end of each transaction and counts it down
// on cache rising edges while idle. A command in the opposite direction to
// the last finished transaction is held off until the count reaches zero.
// Assumes cfg_bubbles is static while out of reset.
module ecs_turnaround #(
    parameter int BUB_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUB_W-1:0] cfg_bubbles,
    input  logic             rise,
    input  logic             busy,
    input  logic             xfer_end,
    input  logic             end_dir,
    input  logic             req_dir,
    input  logic             accept,
    output logic             allow
);

    logic [BUB_W-1:0] gap;
    logic             last_dir;

    // Gap load at transaction end, countdown on idle cache rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap      <= '0;
            last_dir <= 1'b0;
        end else if (xfer_end) begin
            gap      <= cfg_bubbles;
            last_dir <= end_dir;
        end else if (!busy && rise && gap != '0) begin
            gap <= gap - BUB_W'(1);
        end
    end

    // Same direction or an expired gap may start.
    always_comb allow = (req_dir == last_dir) || (gap == '0);

    AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n) accept && (req_dir != last_dir) |-> gap == '0) else $error("turnaround started early"); // R4
    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n) gap <= cfg_bubbles) else $error("gap above setting"); // R4

endmodule

// File: rtl/ecs_burst_ctrl.sv
// Transaction control.
// Holds the accepted operation and address, counts data beats on the enabled
// cache-clock edges, marks the first cache rising edge for tag work and flags
// the end of each transaction. Once busy, nothing can stop the transfer.
// Assumes at least one of cfg_rise_en and cfg_fall_en is set.
module ecs_burst_ctrl
    import ecs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BEATS  = 4,
    localparam int BIDX_W = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              fall,
    input  logic              cfg_rise_en,
    input  logic              cfg_fall_en,
    input  logic              accept,
    input  ecs_op_e           cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              busy,
    output ecs_op_e           op_q,
    output logic [BIDX_W-1:0] beat_idx,
    output logic              data_beat,
    output logic              tag_hit,
    output logic              xfer_end,
    output logic              c_start,
    output logic [ADDR_W-1:0] c_addr
);

    logic tag_pend;
    logic beat_ev;
    logic last_beat;

    // Beat and end decode for the current core cycle.
    always_comb begin
        beat_ev   = (rise && cfg_rise_en) || (fall && cfg_fall_en);
        data_beat = busy && !op_tag_only(op_q) && beat_ev;
        tag_hit   = busy && tag_pend && rise;
        last_beat = (beat_idx == BIDX_W'(BEATS - 1));
        xfer_end  = op_tag_only(op_q) ? tag_hit : (data_beat && last_beat);
    end

    // Transaction state: busy flag, operation, beat count and pending tag slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            op_q     <= OP_DRD;
            beat_idx <= '0;
            tag_pend <= 1'b0;
            c_addr   <= '0;
        end else if (accept) begin
            busy     <= 1'b1;
            op_q     <= cmd_op;
            beat_idx <= '0;
            tag_pend <= (cmd_op != OP_DWR);
            c_addr   <= cmd_addr;
        end else begin
            if (xfer_end)       busy     <= 1'b0;
            if (data_beat)      beat_idx <= beat_idx + BIDX_W'(1);
            if (tag_hit)        tag_pend <= 1'b0;
        end
    end

    // One-cycle start strobe following acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) c_start <= 1'b0;
        else        c_start <= accept;
    end

    AST_READ_RUNS: assert property (@(posedge clk) disable iff (!rst_n) busy && !op_writes(op_q) && !xfer_end |=> busy) else $error("read dropped"); // R10
    AST_NO_REACCEPT: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !accept) else $error("accepted while busy"); // R3
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) c_start |-> busy && !$past(c_start)) else $error("start strobe wrong"); // R3

endmodule

// File: rtl/ecs_line_buf.sv
// Data and tag path.
// Presents write beats in order on the data bus, drives the tag for tag
// writes, gathers read beats into a line and samples the read tag. Control
// strobes come from the transaction controller.
module ecs_line_buf
    import ecs_pkg::*;
#(
    parameter int BEATS  = 4,
    parameter int BEAT_W = 128,
    parameter int TAG_W  = 20,
    localparam int BIDX_W = $clog2(BEATS),
    localparam int LINE_W = BEAT_W * BEATS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  ecs_op_e           cmd_op,
    input  logic [LINE_W-1:0] cmd_wline,
    input  logic [TAG_W-1:0]  cmd_wtag,
    input  logic              busy,
    input  ecs_op_e           op_q,
    input  logic [BIDX_W-1:0] beat_idx,
    input  logic              data_beat,
    input  logic              tag_hit,
    input  logic              xfer_end,
    input  logic              rise,
    input  logic [BEAT_W-1:0] c_rdata,
    input  logic [TAG_W-1:0]  c_tag_in,
    output logic [BEAT_W-1:0] c_wdata,
    output logic              c_data_oe,
    output logic [TAG_W-1:0]  c_tag_out,
    output logic              c_tag_oe,
    output logic              rd_done,
    output logic [LINE_W-1:0] rd_line,
    output logic [TAG_W-1:0]  rd_tag
);

    logic [LINE_W-1:0] wline_q;
    logic [BEAT_W-1:0] wbeat [BEATS];
    logic [BEAT_W-1:0] rbeat [BEATS];
    logic [BIDX_W-1:0] nxt_idx;

    always_comb nxt_idx = beat_idx + BIDX_W'(1);

    // Split the stored write line into beats and join read beats into a line.
    for (genvar g = 0; g < BEATS; g++) begin : g_beat
        assign wbeat[g] = wline_q[g*BEAT_W +: BEAT_W];
        assign rd_line[g*BEAT_W +: BEAT_W] = rbeat[g];

        // Capture read beat g on its beat event.
        always_ff @(posedge clk) begin
            if (!rst_n) rbeat[g] <= '0;
            else if (data_beat && op_q == OP_DRD && beat_idx == BIDX_W'(g))
                rbeat[g] <= c_rdata;
        end
    end

    // Write beat sequencing and data bus enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wline_q   <= '0;
            c_wdata   <= '0;
            c_data_oe <= 1'b0;
        end else if (accept && cmd_op == OP_DWR) begin
            wline_q   <= cmd_wline;
            c_wdata   <= cmd_wline[BEAT_W-1:0];
            c_data_oe <= 1'b1;
        end else if (xfer_end) begin
            c_data_oe <= 1'b0;
        end else if (data_beat && op_q == OP_DWR) begin
            c_wdata <= wbeat[nxt_idx];
        end
    end

    // Tag write drive, held until the first cache rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_tag_out <= '0;
            c_tag_oe  <= 1'b0;
        end else if (accept && cmd_op == OP_TWR) begin
            c_tag_out <= cmd_wtag;
            c_tag_oe  <= 1'b1;
        end else if (tag_hit) begin
            c_tag_oe  <= 1'b0;
        end
    end

    // Read tag sample and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_tag  <= '0;
            rd_done <= 1'b0;
        end else begin
            if (tag_hit && !op_writes(op_q)) rd_tag <= c_tag_in;
            rd_done <= xfer_end && !op_writes(op_q);
        end
    end

    AST_TAG_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(c_tag_out) |-> $past(rise)) else $error("tag moved off rising edge"); // R9
    AST_WDATA_OE: assert property (@(posedge clk) disable iff (!rst_n) c_data_oe |-> busy && op_q == OP_DWR) else $error("data bus driven outside write"); // R6
    AST_TAG_OE: assert property (@(posedge clk) disable iff (!rst_n) c_tag_oe |-> busy && op_q == OP_TWR) else $error("tag bus driven outside tag write"); // R9

endmodule

// File: rtl/ext_cache_seq.sv
// External cache transaction sequencer, top level.
// Accepts one command at a time, starts it on a permitted cache rising edge,
// honours the read/write turnaround gap and moves data and tags through the
// line buffer. The cache clock is described by cfg_half (half core cycles per
// cache cycle); all configuration inputs are static while out of reset.
module ext_cache_seq
    import ecs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BEAT_W = 128,
    parameter int BEATS  = 4,
    parameter int TAG_W  = 20,
    parameter int HALF_W = 4,
    parameter int BUB_W  = 3,
    localparam int LINE_W = BEAT_W * BEATS,
    localparam int BIDX_W = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] cfg_half,
    input  logic              cfg_align,
    input  logic              cfg_rise_en,
    input  logic              cfg_fall_en,
    input  logic [BUB_W-1:0]  cfg_bubbles,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LINE_W-1:0] cmd_wline,
    input  logic [TAG_W-1:0]  cmd_wtag,
    output logic              rd_done,
    output logic [LINE_W-1:0] rd_line,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              c_start,
    output logic [1:0]        c_op,
    output logic [ADDR_W-1:0] c_addr,
    output logic              c_data_oe,
    output logic [BEAT_W-1:0] c_wdata,
    input  logic [BEAT_W-1:0] c_rdata,
    output logic              c_tag_oe,
    output logic [TAG_W-1:0]  c_tag_out,
    input  logic [TAG_W-1:0]  c_tag_in
);

    ecs_op_e           req_op;
    ecs_op_e           op_q;
    logic              rise, rise_al, fall;
    logic              start_ok, allow, accept;
    logic              busy, data_beat, tag_hit, xfer_end;
    logic [BIDX_W-1:0] beat_idx;

    // Handshake: start only on a permitted edge, idle, and past any gap.
    always_comb begin
        req_op    = ecs_op_e'(cmd_op);
        start_ok  = cfg_align ? rise_al : rise;
        cmd_ready = rst_n && !busy && start_ok && allow;
        accept    = cmd_valid && cmd_ready;
        c_op      = op_q;
    end

    ecs_clock_gen #(.HALF_W(HALF_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_half (cfg_half),
        .rise     (rise),
        .rise_al  (rise_al),
        .fall     (fall)
    );

    ecs_turnaround #(.BUB_W(BUB_W)) u_turn (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_bubbles (cfg_bubbles),
        .rise        (rise),
        .busy        (busy),
        .xfer_end    (xfer_end),
        .end_dir     (op_writes(op_q)),
        .req_dir     (op_writes(req_op)),
        .accept      (accept),
        .allow       (allow)
    );

    ecs_burst_ctrl #(.ADDR_W(ADDR_W), .BEATS(BEATS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise        (rise),
        .fall        (fall),
        .cfg_rise_en (cfg_rise_en),
        .cfg_fall_en (cfg_fall_en),
        .accept      (accept),
        .cmd_op      (req_op),
        .cmd_addr    (cmd_addr),
        .busy        (busy),
        .op_q        (op_q),
        .beat_idx    (beat_idx),
        .data_beat   (data_beat),
        .tag_hit     (tag_hit),
        .xfer_end    (xfer_end),
        .c_start     (c_start),
        .c_addr      (c_addr)
    );

    ecs_line_buf #(.BEATS(BEATS), .BEAT_W(BEAT_W), .TAG_W(TAG_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .cmd_op    (req_op),
        .cmd_wline (cmd_wline),
        .cmd_wtag  (cmd_wtag),
        .busy      (busy),
        .op_q      (op_q),
        .beat_idx  (beat_idx),
        .data_beat (data_beat),
        .tag_hit   (tag_hit),
        .xfer_end  (xfer_end),
        .rise      (rise),
        .c_rdata   (c_rdata),
        .c_tag_in  (c_tag_in),
        .c_wdata   (c_wdata),
        .c_data_oe (c_data_oe),
        .c_tag_out (c_tag_out),
        .c_tag_oe  (c_tag_oe),
        .rd_done   (rd_done),
        .rd_line   (rd_line),
        .rd_tag    (rd_tag)
    );

    AST_START_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n) accept |-> rise) else $error("start off rising edge"); // R2
    AST_ALIGNED_START: assert property (@(posedge clk) disable iff (!rst_n) accept && cfg_align |-> rise_al) else $error("unaligned start"); // R2
    AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) rd_done |-> $past(busy) && !$past(op_q[1])) else $error("done without read"); // R7

endmodule

// File: tb/test_ext_cache_seq.sv
`timescale 1ns/100ps
// Sweep bench: every period 4..7 half cycles, both alignment settings, the
// three edge selections and two gap lengths, each with a mixed command list.
module test_ext_cache_seq;
    import ecs_pkg::*;

    localparam int ADDR_W = 32, BEAT_W = 128, BEATS = 4, TAG_W = 20;
    localparam int HALF_W = 4, BUB_W = 3, LINE_W = BEAT_W * BEATS;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic [HALF_W-1:0] cfg_half = HALF_W'(4);
    logic              cfg_align = 1'b0, cfg_rise_en = 1'b1, cfg_fall_en = 1'b0;
    logic [BUB_W-1:0]  cfg_bubbles = '0;
    logic              cmd_valid = 1'b0, cmd_ready;
    logic [1:0]        cmd_op = 2'b00;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [LINE_W-1:0] cmd_wline = '0;
    logic [TAG_W-1:0]  cmd_wtag = '0;
    logic              rd_done, c_start, c_data_oe, c_tag_oe;
    logic [LINE_W-1:0] rd_line;
    logic [TAG_W-1:0]  rd_tag, c_tag_out, c_tag_in;
    logic [1:0]        c_op;
    logic [ADDR_W-1:0] c_addr;
    logic [BEAT_W-1:0] c_wdata, c_rdata;

    ext_cache_seq i_ext_cache_seq (.*);

    int errs = 0, checks = 0, cyc = 0, total = 0, serial = 0;
    int H = 4, NB = 0;

    // Model state.
    logic              busy_e = 0, tagpend_e = 0, done_due = 0, start_due = 0, last_dir_e = 0;
    logic [1:0]        op_e = 2'b00;
    int                beats_e = 0, rises_e = 100;
    logic [LINE_W-1:0] wline_e = '0, exp_line = '0;
    logic [TAG_W-1:0]  wtag_e = '0, exp_tag = '0;
    logic [ADDR_W-1:0] addr_e = '0;

    function automatic logic [LINE_W-1:0] mkline(int k);
        logic [LINE_W-1:0] l;
        for (int w = 0; w < LINE_W / 32; w++) l[w*32 +: 32] = 32'(k * 1000 + w) * 32'h9E3779B1;
        return l;
    endfunction

    function automatic logic [BEAT_W-1:0] gdat(int n);
        logic [BEAT_W-1:0] d;
        for (int w = 0; w < BEAT_W / 32; w++) d[w*32 +: 32] = (32'(n) * 32'h01000193) ^ (32'h5A5A0000 + 32'(w));
        return d;
    endfunction

    function automatic logic [TAG_W-1:0] htag(int n);
        return TAG_W'(n * 13 + 5);
    endfunction

    function automatic int pos(int n);
        return (2 * n) % H;
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        checks++;
        if (ok !== 1'b1) begin
            errs++;
            $display("FAIL %s %s cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    // Cycle index: 0 in the first cycle after reset, as the slot counter.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
        total <= total + 1;
        if (total == 150000) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    // Cache-side inputs as a function of the cycle index.
    always @(posedge clk) begin
        #1;
        c_rdata  = gdat(cyc);
        c_tag_in = htag(cyc);
    end

    // Reference model and output checks, sampled mid-cycle.
    always @(negedge clk) begin
        if (!rst_n) begin
            chk(!cmd_ready && !rd_done && !c_start && !c_data_oe && !c_tag_oe, "R3",
                "reset state", {cmd_ready, rd_done, c_start, c_data_oe, c_tag_oe}, 0);
            busy_e = 0; tagpend_e = 0; done_due = 0; start_due = 0; last_dir_e = 0;
            rises_e = 100;
        end else begin
            automatic int  n    = cyc;
            automatic int  p    = pos(n);
            automatic int  F    = H / 2;
            automatic logic rs  = (p == 0) || (p == H - 1);
            automatic logic fl  = (p == F) || (p == F - 1);
            automatic logic bev = (rs && cfg_rise_en) || (fl && cfg_fall_en);
            automatic logic perm = cfg_align ? (p == 0) : rs;
            automatic logic ended = 0;

            chk(rd_done === done_due, "R7", "rd_done timing", rd_done, done_due);
            if (done_due) begin
                chk(rd_line === exp_line, "R7", "read line", rd_line, exp_line);
                chk(rd_tag === exp_tag, "R8", "read tag", rd_tag, exp_tag);
            end
            done_due = 0;

            if (start_due)
                chk(c_start === 1'b1 && c_addr === addr_e && c_op === op_e, "R3",
                    "start op/addr", {c_start, c_op, c_addr}, {1'b1, op_e, addr_e});
            start_due = 0;

            if (!busy_e)
                chk(!c_data_oe && !c_tag_oe, "R5 R6 R9", "bus enables idle",
                    {c_data_oe, c_tag_oe}, 0);

            if (cmd_valid) begin
                automatic logic pred = !busy_e && perm && (cmd_op[1] == last_dir_e || rises_e >= NB);
                if (busy_e) chk(cmd_ready === pred, "R10", "ready while busy", cmd_ready, pred);
                else        chk(cmd_ready === pred, "R1 R2 R4", "ready at slot", cmd_ready, pred);
            end

            if (busy_e) begin
                if (tagpend_e && rs) begin
                    tagpend_e = 0;
                    if (!op_e[1]) exp_tag = htag(n);
                    if (op_e == OP_TWR)
                        chk(c_tag_oe === 1'b1 && c_tag_out === wtag_e, "R9", "tag write",
                            {c_tag_oe, c_tag_out}, {1'b1, wtag_e});
                    if (op_e[0]) ended = 1;
                end
                if (!op_e[0] && bev) begin
                    if (op_e == OP_DWR)
                        chk(c_data_oe === 1'b1 && c_wdata === wline_e[beats_e*BEAT_W +: BEAT_W], "R6",
                            "write beat", {c_data_oe, c_wdata}, {1'b1, wline_e[beats_e*BEAT_W +: BEAT_W]});
                    else
                        exp_line[beats_e*BEAT_W +: BEAT_W] = gdat(n);
                    beats_e++;
                    if (beats_e == BEATS) ended = 1;
                end
                if (ended) begin
                    busy_e = 0;
                    last_dir_e = op_e[1];
                    rises_e = 0;
                    if (!op_e[1]) done_due = 1;
                end
            end else if (rs && rises_e < 100) begin
                rises_e++;
            end

            if (cmd_valid && cmd_ready) begin
                busy_e = 1; op_e = cmd_op; beats_e = 0;
                tagpend_e = (cmd_op != OP_DWR);
                wline_e = cmd_wline; wtag_e = cmd_wtag; addr_e = cmd_addr;
                start_due = 1;
            end
        end
    end

    // Offer one command and hold it until it is taken.
    task automatic issue(input logic [1:0] op);
        serial++;
        cmd_op    = op;
        cmd_addr  = 32'h0000_0040 * 32'(serial);
        cmd_wline = mkline(serial);
        cmd_wtag  = TAG_W'(serial * 77 + 1);
        cmd_valid = 1'b1;
        do @(negedge clk); while (!cmd_ready);
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
    endtask

    initial begin
        for (int h = 4; h <= 7; h++) begin
            for (int al = 0; al <= 1; al++) begin
                for (int md = 1; md <= 3; md++) begin
                    for (int bb = 0; bb <= 3; bb += 3) begin
                        rst_n = 1'b0;
                        H = h; NB = bb;
                        cfg_half = HALF_W'(h);
                        cfg_align = al[0];
                        cfg_rise_en = md[0];
                        cfg_fall_en = md[1];
                        cfg_bubbles = BUB_W'(bb);
                        repeat (3) @(posedge clk);
                        #1;
                        rst_n = 1'b1;
                        issue(OP_DWR);  // R6 then turnaround into a read (R4)
                        issue(OP_DRD);  // R7 R8, next offered during it (R10)
                        issue(OP_DRD);
                        issue(OP_TWR);  // R9
                        issue(OP_TRD);  // R8
                        issue(OP_DWR);
                        issue(OP_TRD);
                        do @(posedge clk); while (busy_e || done_due);
                        repeat (2) @(posedge clk);
                        #1;
                    end
                end
            end
        end
        summary();
    end

endmodule